// File: doc/BRIEF.md
# Multi-Lane Link Synchronization Qualifier

This block sits above a set of receive lanes. Each lane has its own code-group alignment logic, and each lane reports one ready bit when it has reached its data phase. The block combines these bits into one decision: is the whole link synchronized? It does not declare the link synchronized as soon as every lane looks good. It first runs a qualifying window, and every lane must stay ready for a fixed number of consecutive cycles. If any lane drops out during that window, the wait starts again from the beginning.

The block also counts lane errors at the link level. In each enabled cycle it adds the number of lanes that flag an error. The count saturates at its maximum value. If bring-up fails, the errors seen during bring-up stay in the count so they can be inspected. When the link becomes synchronized, the count is cleared once, because faults from the alignment phase no longer matter. From then on, every error seen while the link is synchronized is kept.

The states are RESET, WAIT_LANES, DEGLITCH and SYNCED. The transitions are:
- enable (RESET to WAIT_LANES)
- all_ready (WAIT_LANES to DEGLITCH)
- lane_drop (DEGLITCH to WAIT_LANES)
- qualified (DEGLITCH to SYNCED)
- disable (any state to RESET)

SYNCED is left only through disable or through reset.

Top module: `link_sync_qual`

## Requirements
- R1: When `enable` is low at a clock edge, the state becomes RESET at that edge, whatever the current state. The state encoding on `link_state` is RESET=0, WAIT_LANES=1, DEGLITCH=2, SYNCED=3.
- R2: When the state is RESET and `enable` is high at an edge, the state becomes WAIT_LANES.
- R3: Consider the edges at which every bit of `lane_ready` is high, counted from an edge seen in WAIT_LANES. `sync_ok` rises after exactly QUAL_CYCLES such consecutive edges and not before. After QUAL_CYCLES-1 such edges, the state is DEGLITCH.
- R4: In DEGLITCH, if any `lane_ready` bit is low at an edge, the state returns to WAIT_LANES. The next qualifying run then starts again from zero.
- R5: In SYNCED, the state and `sync_ok` stay set while `enable` is high, whatever `lane_ready` does.
- R6: While `enable` is high, each edge adds the number of set bits in `lane_err` to `err_count`. While `enable` is low, `err_count` holds its value.
- R7: At the edge that enters SYNCED, `err_count` becomes 0. Any errors flagged in that same cycle are discarded.
- R8: `err_count` saturates at 2^ERR_W-1 and never wraps.
- R9: While `rst_n` is low: `link_state` is RESET, `sync_ok` is 0 and `err_count` is 0.
- R10: Errors collected before synchronization are kept across lane drops back to WAIT_LANES. They are also kept in RESET.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Link enable; low forces RESET |
| lane_ready | input | NUM_LANES | Per-lane data-phase indication |
| lane_err | input | NUM_LANES | Per-lane error pulse, one cycle per event |
| link_state | output | 2 | Current link state code |
| sync_ok | output | 1 | High in SYNCED |
| err_count | output | ERR_W | Saturating link error count |

## Verification
The hardest case to reach is a lane that drops out at a late point of the qualifying window. This means every position from the second ready cycle up to the last one before the window completes.

The stimulus steps through every drop position from 1 to QUAL_CYCLES-1. Each time, it keeps all lanes ready for that many edges and then clears one lane, rotating which lane is cleared. The bench then checks that the state returns to WAIT_LANES and that the link never becomes synchronized. The same sweep injects errors so that the count reaches saturation before synchronization.

The final complete run then checks two things:
- The exact edge at which `sync_ok` rises.
- That the count is cleared at that edge, even though errors are injected in that same cycle.

// File: rtl/link_sync_qual_pkg.sv
package link_sync_qual_pkg;

    typedef enum logic [1:0] {
        S_RESET      = 2'd0,
        S_WAIT_LANES = 2'd1,
        S_DEGLITCH   = 2'd2,
        S_SYNCED     = 2'd3
    } link_state_t;

endpackage

// File: rtl/lsq_fsm.sv
module lsq_fsm
    import link_sync_qual_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_LANES-1:0] lane_ready,
    output link_state_t          state_o,
    output logic                 enter_sync_o
);
    localparam int CNT_W = (QUAL_CYCLES > 2) ? $clog2(QUAL_CYCLES) : 1;
    localparam logic [CNT_W-1:0] QUAL_LAST = CNT_W'(QUAL_CYCLES - 1);

    link_state_t      state_q, state_d;
    logic [CNT_W-1:0] run_q, run_d;
    logic             all_ready;

    assign all_ready = &lane_ready;

    // next-state logic; run_q counts ready cycles, including the WAIT_LANES one
    always_comb begin
        state_d = state_q;
        run_d   = run_q;
        if (!enable) begin
            state_d = S_RESET;
            run_d   = '0;
        end else begin
            unique case (state_q)
                S_RESET: begin
                    state_d = S_WAIT_LANES;
                    run_d   = '0;
                end
                S_WAIT_LANES: begin
                    if (all_ready) begin
                        state_d = S_DEGLITCH;
                        run_d   = CNT_W'(1);
                    end
                end
                S_DEGLITCH: begin
                    if (!all_ready) begin
                        state_d = S_WAIT_LANES;
                        run_d   = '0;
                    end else if (run_q == QUAL_LAST) begin
                        state_d = S_SYNCED;
                        run_d   = '0;
                    end else begin
                        run_d = run_q + CNT_W'(1);
                    end
                end
                S_SYNCED: begin
                    state_d = S_SYNCED;
                end
                default: begin
                    state_d = S_RESET;
                    run_d   = '0;
                end
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_RESET;
            run_q   <= '0;
        end else begin
            state_q <= state_d;
            run_q   <= run_d;
        end
    end

    always_comb begin
        state_o      = state_q;
        enter_sync_o = (state_q == S_DEGLITCH) && (state_d == S_SYNCED);
    end

    // R1
    p_disable_resets_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |=> state_q == S_RESET);
    // R4
    p_drop_restarts_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == S_DEGLITCH && !all_ready) |=> (state_q == S_WAIT_LANES && run_q == '0));
    // R3
    p_full_run_syncs_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && state_q == S_DEGLITCH && all_ready && run_q == QUAL_LAST) |=> state_q == S_SYNCED);
    // R3
    p_deglitch_run_nonzero_r3: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == S_DEGLITCH |-> run_q != '0);
    // R5
    p_sync_sticky_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_SYNCED && enable) |=> state_q == S_SYNCED);
endmodule

// File: rtl/lsq_err_acc.sv
module lsq_err_acc #(
    parameter int NUM_LANES = 4,
    parameter int ERR_W     = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 count_en,
    input  logic                 clear,
    input  logic [NUM_LANES-1:0] lane_err,
    output logic [ERR_W-1:0]     err_count
);
    localparam int PC_W = $clog2(NUM_LANES + 1);
    localparam logic [ERR_W-1:0] ERR_MAX = {ERR_W{1'b1}};

    logic [PC_W-1:0]  hits;
    logic [ERR_W:0]   sum_wide;
    logic [ERR_W-1:0] cnt_q;

    always_comb begin
        hits = '0;
        for (int i = 0; i < NUM_LANES; i++) begin
            hits = hits + PC_W'(lane_err[i]);
        end
        sum_wide = {1'b0, cnt_q} + (ERR_W + 1)'(hits);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear) begin
            cnt_q <= '0;
        end else if (count_en) begin
            cnt_q <= sum_wide[ERR_W] ? ERR_MAX : sum_wide[ERR_W-1:0];
        end
    end

    assign err_count = cnt_q;

    // R8
    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == ERR_MAX && !clear) |=> cnt_q == ERR_MAX);
    // R6
    p_hold_when_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!count_en && !clear) |=> $stable(cnt_q));
    // R7
    p_clear_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        clear |=> cnt_q == '0);
endmodule

// File: rtl/link_sync_qual.sv
module link_sync_qual
    import link_sync_qual_pkg::*;
#(
    parameter int NUM_LANES   = 4,
    parameter int QUAL_CYCLES = 256,
    parameter int ERR_W       = 32
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 enable,
    input  logic [NUM_LANES-1:0] lane_ready,
    input  logic [NUM_LANES-1:0] lane_err,
    output logic [1:0]           link_state,
    output logic                 sync_ok,
    output logic [ERR_W-1:0]     err_count
);
    link_state_t state;
    logic        enter_sync;

    lsq_fsm #(
        .NUM_LANES  (NUM_LANES),
        .QUAL_CYCLES(QUAL_CYCLES)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .enable      (enable),
        .lane_ready  (lane_ready),
        .state_o     (state),
        .enter_sync_o(enter_sync)
    );

    lsq_err_acc #(
        .NUM_LANES(NUM_LANES),
        .ERR_W    (ERR_W)
    ) u_err (
        .clk      (clk),
        .rst_n    (rst_n),
        .count_en (enable),
        .clear    (enter_sync),
        .lane_err (lane_err),
        .err_count(err_count)
    );

    always_comb begin
        link_state = state;
        sync_ok    = (state == S_SYNCED);
    end

    // R7
    p_zero_on_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sync_ok) |-> err_count == '0);
    // R2
    p_leave_reset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && link_state == 2'd0) |=> link_state == 2'd1);
endmodule

// File: tb/test_link_sync_qual.sv
module test_link_sync_qual;
    localparam int NL   = 4;
    localparam int QUAL = 256;
    localparam int EW   = 8;
    localparam int EMAX = (1 << EW) - 1;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          enable;
    logic [NL-1:0] lane_ready;
    logic [NL-1:0] lane_err;
    logic [1:0]    link_state;
    logic          sync_ok;
    logic [EW-1:0] err_count;

    int total = 0;
    int bad   = 0;
    int exp_err = 0;

    always #2.5 clk = ~clk;

    link_sync_qual #(.NUM_LANES(NL), .QUAL_CYCLES(QUAL), .ERR_W(EW)) i_link_sync_qual (
        .clk(clk), .rst_n(rst_n), .enable(enable), .lane_ready(lane_ready),
        .lane_err(lane_err), .link_state(link_state), .sync_ok(sync_ok), .err_count(err_count)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int pop(input logic [NL-1:0] v);
        int n = 0;
        for (int i = 0; i < NL; i++) n += int'(v[i]);
        return n;
    endfunction

    function automatic int sat(input int v);
        return (v > EMAX) ? EMAX : v;
    endfunction

    initial begin
        #1_000_000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0; enable = 1'b0; lane_ready = '0; lane_err = '0;
        tick(); tick();
        chk("R9 state", int'(link_state), 0);
        chk("R9 sync", int'(sync_ok), 0);
        chk("R9 count", int'(err_count), 0);
        rst_n = 1'b1;
        // errors while disabled are not counted
        lane_err = '1; tick(); lane_err = '0;
        chk("R6 hold disabled", int'(err_count), 0);
        enable = 1'b1; tick();
        chk("R2 to wait", int'(link_state), 1);
        // exhaustive error pattern sweep in WAIT_LANES
        for (int p = 0; p < (1 << NL); p++) begin
            lane_err = NL'(p); tick();
            exp_err = sat(exp_err + pop(NL'(p)));
            chk("R6 accumulate", int'(err_count), exp_err);
        end
        lane_err = '0;
        // partial readiness keeps WAIT_LANES
        lane_ready = 4'b0111; tick(); tick();
        chk("R4 partial ready stays wait", int'(link_state), 1);
        // drop sweep across every position of the window
        for (int d = 1; d < QUAL; d++) begin
            lane_ready = '1;
            for (int k = 0; k < d; k++) begin
                lane_err = (k == 0) ? NL'(1 << (d % NL)) : '0;
                tick();
                if (k == 0) exp_err = sat(exp_err + 1);
            end
            lane_err = '0;
            chk("R3 in deglitch before drop", int'(link_state), 2);
            lane_ready = ~NL'(1 << (d % NL)); tick();
            chk("R4 drop to wait", int'(link_state), 1);
            chk("R4 not synced", int'(sync_ok), 0);
        end
        chk("R10 errors kept", int'(err_count), exp_err);
        chk("R8 saturated", int'(err_count), EMAX);
        lane_err = '1; tick(); lane_err = '0;
        chk("R8 no wrap", int'(err_count), EMAX);
        // complete run
        lane_ready = '1;
        for (int k = 0; k < QUAL - 1; k++) tick();
        chk("R3 one short", int'(sync_ok), 0);
        chk("R3 one short state", int'(link_state), 2);
        lane_err = '1; tick(); lane_err = '0;
        chk("R3 synced", int'(sync_ok), 1);
        chk("R3 state synced", int'(link_state), 3);
        chk("R7 cleared", int'(err_count), 0);
        exp_err = 0;
        // sticky while lanes misbehave
        lane_ready = '0; tick(); tick();
        chk("R5 sticky", int'(sync_ok), 1);
        for (int p = 0; p < (1 << NL); p++) begin
            lane_err = NL'(p); tick();
            exp_err = sat(exp_err + pop(NL'(p)));
        end
        lane_err = '0;
        chk("R6 synced count", int'(err_count), exp_err);
        enable = 1'b0; lane_err = 4'b0011; tick(); lane_err = '0;
        chk("R1 disable from synced", int'(link_state), 0);
        chk("R1 sync dropped", int'(sync_ok), 0);
        chk("R6 held when disabled", int'(err_count), exp_err);
        chk("R10 kept in reset", int'(err_count), exp_err);
        // disable from DEGLITCH
        enable = 1'b1; tick();
        lane_ready = '1; tick();
        chk("R3 enter deglitch", int'(link_state), 2);
        enable = 1'b0; tick();
        chk("R1 disable from deglitch", int'(link_state), 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule